// File: doc/BRIEF.md
# Multi-core interrupt routing controller

This block gathers a bank of level-sensitive interrupt sources and steers each one to a single output pin of a single processor core. Every source carries a pending bit that follows its input and an enable bit set by software. Each core has its own status bank, in which a source appears only while it is pending, enabled and routed to that core. A per-source core map picks the destination core, and a per-group pin map (one entry per 32 sources) picks the pin on that core. Each core/pin output stays high while any routed source is set in that core's status for that pin.

Software reaches the registers through a 32-bit word port with a requester core ID. The ID picks which core's status bank a status read or write-1-to-clear write acts on. Rewriting the core map of a pending source moves it live: it is withdrawn from the old core and raised at the new one. Rewriting an enable word raises or withdraws every pending source whose enable bit changed. Bounce and node-type words are kept only for software and do not affect routing.

Register layout (byte offsets on the low 16 address bits, little-endian within each 32-bit word): core map 0x000 (byte s = source s), pin map 0x100 (byte g = group g), enable 0x200 + 4g, pending 0x280 + 4g (read-only), status 0x300 + 4g, bounce 0x380 + 4g, node type 0x400 + 4k (k < 4), mode 0x800 (bit 0 = encoded-core mode). The window is 0x900 bytes. The output for core c, pin p is `irq_o[c*NUM_PIN + p]`.

Top module: `irq_route_ctrl`

## Requirements
- R1: A source input that goes from low to high sets its pending bit whatever its enable bit. A source that goes low clears its pending bit. Pending word g reads at 0x280 + 4g, bit s%32, and is updated on the first clock edge that sees the new level.
- R2: A rising source enters the status bank of its routed core only when its enable bit is 1. Status word g of core k reads at 0x300 + 4g with requester ID k.
- R3: Pin-map byte g (byte lane g%4 of word 0x100 + 4*(g/4)) routes group g to the pin given by the index of its lowest set bit. A zero byte, or an index of NUM_PIN or more, selects pin 0.
- R4: With the mode bit clear, core-map byte s (offset s, lane s%4) routes source s to the core given by the index of its lowest set bit. A zero byte, or an index of NUM_CORE or more, selects core 0.
- R5: With mode bit 0 of 0x800 set, a core-map write uses the byte value itself as the core number, and a value of NUM_CORE or more selects core 0. The mode in force when a core-map byte is written sets the route. Changing the mode later does not re-route sources.
- R6: A core-map write that changes the target of a pending, enabled source clears the source from the old core's status and sets it in the new core's status in the same cycle.
- R7: An enable write raises, at its routed core, every pending source whose enable bit goes from 0 to 1. It withdraws every source whose enable bit goes from 1 to 0.
- R8: A write to a status word clears the bits written as 1 in the bank of the requester core only. Other cores and the pending bits are unchanged.
- R9: Output c*NUM_PIN+p is high one clock after any status bit of core c lies in a group routed to pin p. It stays high until the last such bit clears.
- R10: Bounce and node-type words read back what was written and have no effect on any output.
- R11: Only address bits 15:0 are decoded. Offsets of 0x900 and above, and other unmapped offsets, read as zero, and writes to them are ignored. Writes to the pending words are ignored.
- R12: Read data appears on bus_rdata_o on the clock edge that samples bus_rd_i and is zero in every other cycle. A synchronous active-high reset clears every register bank, the read data and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt sources |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 32 | Byte address; bits 15:0 decoded |
| bus_wdata_i | input | 32 | Write data |
| bus_req_i | input | CORE_W | Requester core ID, selects the status bank |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | NUM_CORE*NUM_PIN | Per-core, per-pin interrupt levels |

## Verification
The assertions assume that bus_req_i names an existing core and that a read and a write are never issued in the same cycle. The bench keeps to both: every access sets exactly one strobe, and requester IDs range over 0 to 3. They also assume that a source, an enable write and a core-map write for the same source do not land in one cycle. The bench changes each of these in a separate step and lets outputs settle for two clocks before it samples.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // Byte offsets inside the register window (low 16 address bits)
  localparam logic [15:0] OFF_CMAP = 16'h0000;
  localparam logic [15:0] OFF_PMAP = 16'h0100;
  localparam logic [15:0] OFF_EN   = 16'h0200;
  localparam logic [15:0] OFF_PEND = 16'h0280;
  localparam logic [15:0] OFF_STAT = 16'h0300;
  localparam logic [15:0] OFF_BNC  = 16'h0380;
  localparam logic [15:0] OFF_NODE = 16'h0400;
  localparam logic [15:0] OFF_MODE = 16'h0800;
  localparam logic [15:0] WIN_SIZE = 16'h0900;

  // Position of the lowest set bit of a byte, 8 when the byte is zero
  function automatic int unsigned low_set_idx(input logic [7:0] b);
    int unsigned r;
    r = 8;
    for (int i = 7; i >= 0; i--) begin
      if (b[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/irq_route_map_dec.sv
module irq_route_map_dec #(
  parameter int IDX_W = 2,
  parameter int LIMIT = 4
) (
  input  logic [7:0]       code_i,
  input  logic             direct_i,
  output logic [IDX_W-1:0] idx_o
);
  import irq_route_pkg::*;

  always_comb begin
    int unsigned v;
    v = direct_i ? int'(code_i) : low_set_idx(code_i);
    idx_o = (v >= LIMIT) ? '0 : IDX_W'(v);
  end

endmodule

// File: rtl/irq_route_pin_or.sv
module irq_route_pin_or #(
  parameter int NUM_SRC = 64,
  parameter int NUM_PIN = 4,
  parameter int PIN_W   = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_SRC-1:0]              stat_i,
  input  logic [(NUM_SRC/32)*PIN_W-1:0]   grp_pin_i,
  output logic [NUM_PIN-1:0]              lvl_o
);
  localparam int NUM_GRP = NUM_SRC / 32;

  logic [NUM_PIN-1:0] lvl_d;

  always_comb begin
    lvl_d = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (|stat_i[32*g +: 32]) lvl_d[grp_pin_i[g*PIN_W +: PIN_W]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_o <= '0;
    else     lvl_o <= lvl_d;
  end

  // R9: a core with an empty status bank drives every pin low next cycle
  a_r9_idle_core_low: assert property (@(posedge clk) disable iff (rst)
    (stat_i == '0) |=> (lvl_o == '0));

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl #(
  parameter int NUM_SRC    = 64,
  parameter int NUM_CORE   = 4,
  parameter int NUM_PIN    = 4,
  parameter int NODE_WORDS = 4,
  parameter int CORE_W     = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_SRC-1:0]           src_i,
  input  logic                         bus_wr_i,
  input  logic                         bus_rd_i,
  input  logic [31:0]                  bus_addr_i,
  input  logic [31:0]                  bus_wdata_i,
  input  logic [CORE_W-1:0]            bus_req_i,
  output logic [31:0]                  bus_rdata_o,
  output logic [NUM_CORE*NUM_PIN-1:0]  irq_o
);
  import irq_route_pkg::*;

  localparam int NUM_GRP    = NUM_SRC / 32;
  localparam int PIN_W      = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1;
  localparam int CMAP_WORDS = NUM_SRC / 4;
  localparam int PMAP_WORDS = (NUM_GRP + 3) / 4;

  // ---------------- address decode ----------------
  logic [15:0] off, r_cm, r_pm, r_en, r_pd, r_st, r_bn, r_nd;
  logic        hit_cm, hit_pm, hit_en, hit_pd, hit_st, hit_bn, hit_nd, hit_md;

  assign off  = bus_addr_i[15:0];
  assign r_cm = off - OFF_CMAP;
  assign r_pm = off - OFF_PMAP;
  assign r_en = off - OFF_EN;
  assign r_pd = off - OFF_PEND;
  assign r_st = off - OFF_STAT;
  assign r_bn = off - OFF_BNC;
  assign r_nd = off - OFF_NODE;

  assign hit_cm = r_cm < 16'(4 * CMAP_WORDS);
  assign hit_pm = r_pm < 16'(4 * PMAP_WORDS);
  assign hit_en = r_en < 16'(4 * NUM_GRP);
  assign hit_pd = r_pd < 16'(4 * NUM_GRP);
  assign hit_st = r_st < 16'(4 * NUM_GRP);
  assign hit_bn = r_bn < 16'(4 * NUM_GRP);
  assign hit_nd = r_nd < 16'(4 * NODE_WORDS);
  assign hit_md = (off[15:2] == OFF_MODE[15:2]);

  // ---------------- state ----------------
  logic [NUM_SRC-1:0] src_q, pend_q, pend_d, en_q, en_d;
  logic [NUM_SRC-1:0] stat_q [NUM_CORE];
  logic [NUM_SRC-1:0] stat_d [NUM_CORE];
  logic [7:0]         cmap_q [NUM_SRC];
  logic [CORE_W-1:0]  core_q [NUM_SRC];
  logic [CORE_W-1:0]  core_d [NUM_SRC];
  logic [7:0]         pmap_q [NUM_GRP];
  logic [31:0]        bnc_q  [NUM_GRP];
  logic [31:0]        node_q [NODE_WORDS];
  logic               mode_q;
  logic [31:0]        rdata_d, rdata_q;

  logic [CORE_W-1:0]        lane_core [4];
  logic [NUM_GRP*PIN_W-1:0] grp_pin;

  // Decode the four core-map lanes of the incoming write with the current mode
  for (genvar l = 0; l < 4; l++) begin : g_lane
    irq_route_map_dec #(.IDX_W(CORE_W), .LIMIT(NUM_CORE)) u_cdec (
      .code_i   (bus_wdata_i[8*l +: 8]),
      .direct_i (mode_q),
      .idx_o    (lane_core[l])
    );
  end

  // Decode each group's pin byte (always lowest-set-bit form)
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_pin
    irq_route_map_dec #(.IDX_W(PIN_W), .LIMIT(NUM_PIN)) u_pdec (
      .code_i   (pmap_q[g]),
      .direct_i (1'b0),
      .idx_o    (grp_pin[g*PIN_W +: PIN_W])
    );
  end

  // ---------------- next-state: enable ----------------
  always_comb begin
    en_d = en_q;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (bus_wr_i && hit_en && r_en[15:2] == 14'(g)) en_d[32*g +: 32] = bus_wdata_i;
    end
  end

  // ---------------- next-state: pending, routing, status ----------------
  always_comb begin
    logic rise, fall, cm_hit, moved, en_up, en_dn, w1c_hit, clr, set;
    logic [CORE_W-1:0] new_core;
    for (int c = 0; c < NUM_CORE; c++) stat_d[c] = stat_q[c];
    for (int s = 0; s < NUM_SRC; s++) begin
      rise     = src_i[s] & ~src_q[s];
      fall     = ~src_i[s] & src_q[s];
      cm_hit   = bus_wr_i && hit_cm && (r_cm[15:2] == 14'(s / 4));
      new_core = cm_hit ? lane_core[s % 4] : core_q[s];
      moved    = cm_hit && (new_core != core_q[s]);
      en_up    = en_d[s] & ~en_q[s];
      en_dn    = en_q[s] & ~en_d[s];
      w1c_hit  = bus_wr_i && hit_st && (r_st[15:2] == 14'(s / 32)) && bus_wdata_i[s % 32];
      pend_d[s] = rise | (pend_q[s] & ~fall);
      core_d[s] = new_core;
      for (int c = 0; c < NUM_CORE; c++) begin
        clr = ((core_q[s] == CORE_W'(c)) && (fall || en_dn || moved)) ||
              (w1c_hit && (bus_req_i == CORE_W'(c)));
        set = (new_core == CORE_W'(c)) && en_d[s] && pend_d[s] && (rise || en_up || moved);
        stat_d[c][s] = (stat_q[c][s] & ~clr) | set;
      end
    end
  end

  // ---------------- read mux ----------------
  always_comb begin
    rdata_d = '0;
    if (bus_rd_i) begin
      if (hit_cm) begin
        for (int s = 0; s < NUM_SRC; s++)
          if (r_cm[15:2] == 14'(s / 4)) rdata_d[8*(s%4) +: 8] = cmap_q[s];
      end else if (hit_pm) begin
        for (int g = 0; g < NUM_GRP; g++)
          if (r_pm[15:2] == 14'(g / 4)) rdata_d[8*(g%4) +: 8] = pmap_q[g];
      end else if (hit_en || hit_pd || hit_st || hit_bn) begin
        for (int g = 0; g < NUM_GRP; g++) begin
          if (hit_en && r_en[15:2] == 14'(g)) rdata_d = en_q[32*g +: 32];
          if (hit_pd && r_pd[15:2] == 14'(g)) rdata_d = pend_q[32*g +: 32];
          if (hit_st && r_st[15:2] == 14'(g)) rdata_d = stat_q[bus_req_i][32*g +: 32];
          if (hit_bn && r_bn[15:2] == 14'(g)) rdata_d = bnc_q[g];
        end
      end else if (hit_nd) begin
        for (int k = 0; k < NODE_WORDS; k++)
          if (r_nd[15:2] == 14'(k)) rdata_d = node_q[k];
      end else if (hit_md) begin
        rdata_d = {31'd0, mode_q};
      end
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      src_q   <= '0;
      pend_q  <= '0;
      en_q    <= '0;
      mode_q  <= 1'b0;
      rdata_q <= '0;
      for (int c = 0; c < NUM_CORE; c++) stat_q[c] <= '0;
      for (int s = 0; s < NUM_SRC; s++) begin
        cmap_q[s] <= '0;
        core_q[s] <= '0;
      end
      for (int g = 0; g < NUM_GRP; g++) begin
        pmap_q[g] <= '0;
        bnc_q[g]  <= '0;
      end
      for (int k = 0; k < NODE_WORDS; k++) node_q[k] <= '0;
    end else begin
      src_q   <= src_i;
      pend_q  <= pend_d;
      en_q    <= en_d;
      rdata_q <= rdata_d;
      for (int c = 0; c < NUM_CORE; c++) stat_q[c] <= stat_d[c];
      for (int s = 0; s < NUM_SRC; s++) begin
        core_q[s] <= core_d[s];
        if (bus_wr_i && hit_cm && r_cm[15:2] == 14'(s / 4))
          cmap_q[s] <= bus_wdata_i[8*(s%4) +: 8];
      end
      for (int g = 0; g < NUM_GRP; g++) begin
        if (bus_wr_i && hit_pm && r_pm[15:2] == 14'(g / 4))
          pmap_q[g] <= bus_wdata_i[8*(g%4) +: 8];
        if (bus_wr_i && hit_bn && r_bn[15:2] == 14'(g))
          bnc_q[g] <= bus_wdata_i;
      end
      for (int k = 0; k < NODE_WORDS; k++)
        if (bus_wr_i && hit_nd && r_nd[15:2] == 14'(k)) node_q[k] <= bus_wdata_i;
      if (bus_wr_i && hit_md) mode_q <= bus_wdata_i[0];
    end
  end

  assign bus_rdata_o = rdata_q;

  // ---------------- per-core pin levels ----------------
  for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
    irq_route_pin_or #(.NUM_SRC(NUM_SRC), .NUM_PIN(NUM_PIN), .PIN_W(PIN_W)) u_por (
      .clk       (clk),
      .rst       (rst),
      .stat_i    (stat_q[c]),
      .grp_pin_i (grp_pin),
      .lvl_o     (irq_o[c*NUM_PIN +: NUM_PIN])
    );

    // R2: a status bit never stands without its pending bit
    a_r2_stat_needs_pending: assert property (@(posedge clk) disable iff (rst)
      (stat_q[c] & ~pend_q) == '0);

    // R7: a status bit never stands without its enable bit
    a_r7_stat_needs_enable: assert property (@(posedge clk) disable iff (rst)
      (stat_q[c] & ~en_q) == '0);
  end

  // R6: a source is live at no more than one core at a time
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_col
    logic [NUM_CORE-1:0] col;
    for (genvar c = 0; c < NUM_CORE; c++) begin : g_bit
      assign col[c] = stat_q[c][s];
    end
    a_r6_single_core: assert property (@(posedge clk) disable iff (rst) $onehot0(col));
  end

  // R11: reads beyond the window return zero
  a_r11_unmapped_read_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && bus_addr_i[15:0] >= WIN_SIZE) |=> (bus_rdata_o == '0));

  // R12: reset leaves outputs and read data quiet
  a_r12_reset_quiet: assert property (@(posedge clk)
    rst |=> (irq_o == '0 && bus_rdata_o == '0));

endmodule

// File: tb/tb_irq_route_ctrl.sv
module tb_irq_route_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NSRC-1:0] src = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [1:0]  req = '0;
  logic [31:0] rdata;
  logic [15:0] irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_route_ctrl dut (
    .clk(clk), .rst(rst), .src_i(src), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_req_i(req),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [31:0] a, input logic [31:0] d, input logic [1:0] id);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d; req = id;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [31:0] a, input logic [1:0] id, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a; req = id;
    @(negedge clk);
    d = rdata;
    rd = 1'b0;
  endtask

  task automatic set_src(input int i, input logic v);
    @(negedge clk);
    src[i] = v;
  endtask

  task automatic chk_irq(input string tag, input logic [15:0] exp);
    repeat (2) @(posedge clk);
    #1;
    chk(tag, {16'd0, irq}, {16'd0, exp});
  endtask

  task automatic chk_rd(input string tag, input logic [31:0] a, input logic [1:0] id,
                        input logic [31:0] exp);
    logic [31:0] d;
    rd_reg(a, id, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset_state();
    chk_irq("R12 outputs low after reset", 16'h0000);
    chk_rd("R12 enable cleared", 32'h200, 2'd0, 32'h0);
    chk_rd("R12 core map cleared", 32'h000, 2'd0, 32'h0);
  endtask

  task automatic t_pending_enable();
    set_src(3, 1'b1);
    chk_irq("R2 disabled source stays off", 16'h0000);
    chk_rd("R1 pending set while disabled", 32'h280, 2'd0, 32'h0000_0008);
    chk_rd("R2 status empty while disabled", 32'h300, 2'd0, 32'h0);
    wr_reg(32'h200, 32'h0000_0008, 2'd0);
    chk_irq("R7 enabling pending source raises core0 pin0", 16'h0001);
    chk_rd("R2 status of core0", 32'h300, 2'd0, 32'h0000_0008);
  endtask

  task automatic t_pin_map();
    // group0 byte 0x04 -> pin2, group1 byte 0x30 -> index 4 -> pin0
    wr_reg(32'h100, 32'h0000_3004, 2'd0);
    chk_irq("R3 group0 routed to pin2", 16'h0004);
    chk_rd("R3 pin map readback", 32'h100, 2'd0, 32'h0000_3004);
  endtask

  task automatic t_core_map();
    wr_reg(32'h000, 32'h0400_0000, 2'd0);   // source3 byte 0x04 -> core2
    chk_irq("R6 pending source moved to core2", 16'h0400);
    chk_rd("R6 old core status cleared", 32'h300, 2'd0, 32'h0);
    chk_rd("R6 new core status set", 32'h300, 2'd2, 32'h0000_0008);
    chk_rd("R4 core map readback", 32'h000, 2'd0, 32'h0400_0000);
    wr_reg(32'h000, 32'h2000_0000, 2'd0);   // bit5 -> out of range -> core0
    chk_irq("R4 index above core count selects core0", 16'h0004);
  endtask

  task automatic t_encoded();
    wr_reg(32'h800, 32'h1, 2'd0);
    chk_rd("R5 mode readback", 32'h800, 2'd0, 32'h1);
    wr_reg(32'h000, 32'h0200_0000, 2'd0);   // value 2 -> core2
    chk_irq("R5 encoded value 2 routes to core2", 16'h0400);
    wr_reg(32'h000, 32'h0600_0000, 2'd0);   // value 6 -> out of range -> core0
    chk_irq("R5 encoded value 6 routes to core0", 16'h0004);
    wr_reg(32'h000, 32'h0300_0000, 2'd0);   // value 3 -> core3
    chk_irq("R5 encoded value 3 routes to core3", 16'h4000);
    wr_reg(32'h800, 32'h0, 2'd0);
    chk_irq("R5 clearing mode keeps existing route", 16'h4000);
    wr_reg(32'h000, 32'h0300_0000, 2'd0);   // default: lowest bit 0 -> core0
    chk_irq("R4 byte 0x03 in default mode routes to core0", 16'h0004);
  endtask

  task automatic t_w1c();
    set_src(40, 1'b1);
    wr_reg(32'h204, 32'h0000_0100, 2'd0);
    chk_irq("R9 two pins of core0 high", 16'h0005);
    wr_reg(32'h300, 32'h0000_0008, 2'd1);
    chk_irq("R8 clear by other core has no effect", 16'h0005);
    chk_rd("R8 core0 status untouched", 32'h300, 2'd0, 32'h0000_0008);
    wr_reg(32'h300, 32'h0000_0008, 2'd0);
    chk_irq("R8 own clear drops pin2", 16'h0001);
    chk_rd("R8 status bit cleared", 32'h300, 2'd0, 32'h0);
    chk_rd("R8 pending kept after clear", 32'h280, 2'd0, 32'h0000_0008);
  endtask

  task automatic t_shared_pin();
    set_src(4, 1'b1);
    set_src(5, 1'b1);
    wr_reg(32'h200, 32'h0000_0038, 2'd0);
    chk_irq("R9 shared pin raised", 16'h0005);
    set_src(4, 1'b0);
    chk_irq("R9 pin held by remaining source", 16'h0005);
    chk_rd("R1 falling source clears its status", 32'h300, 2'd0, 32'h0000_0020);
    set_src(5, 1'b0);
    chk_irq("R9 pin falls with last source", 16'h0001);
    chk_rd("R1 pending after falls", 32'h280, 2'd0, 32'h0000_0008);
  endtask

  task automatic t_disable();
    wr_reg(32'h204, 32'h0, 2'd0);
    chk_irq("R7 disabling withdraws source", 16'h0000);
    chk_rd("R7 pending survives disable", 32'h284, 2'd0, 32'h0000_0100);
    wr_reg(32'h204, 32'h0000_0100, 2'd0);
    chk_irq("R7 re-enable raises again", 16'h0001);
  endtask

  task automatic t_store_only();
    wr_reg(32'h380, 32'hA5A5_0001, 2'd0);
    wr_reg(32'h404, 32'h0000_1234, 2'd0);
    chk_irq("R10 bounce and node words leave outputs", 16'h0001);
    chk_rd("R10 bounce readback", 32'h380, 2'd0, 32'hA5A5_0001);
    chk_rd("R10 node readback", 32'h404, 2'd0, 32'h0000_1234);
  endtask

  task automatic t_decode();
    chk_rd("R11 read beyond window", 32'h900, 2'd0, 32'h0);
    wr_reg(32'h280, 32'hFFFF_FFFF, 2'd0);
    chk_rd("R11 pending not writable", 32'h280, 2'd0, 32'h0000_0008);
    wr_reg(32'h950, 32'hFFFF_FFFF, 2'd0);
    chk_rd("R11 unmapped write ignored", 32'h200, 2'd0, 32'h0000_0038);
    wr_reg(32'h0001_0204, 32'h0, 2'd0);
    chk_irq("R11 high address bits ignored on write", 16'h0000);
    chk_rd("R11 high address bits ignored on read", 32'hABCD_0200, 2'd0, 32'h0000_0038);
    @(negedge clk);
    #1;
    chk("R12 read data zero when idle", rdata, 32'h0);
  endtask

  task automatic t_reset_again();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R12 outputs low during reset", {16'd0, irq}, 32'h0);
    rst = 1'b0;
    chk_rd("R12 bounce cleared", 32'h380, 2'd0, 32'h0);
    chk_rd("R12 pin map cleared", 32'h100, 2'd0, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_pending_enable();
    t_pin_map();
    t_core_map();
    t_encoded();
    t_w1c();
    t_shared_pin();
    t_disable();
    t_store_only();
    t_decode();
    t_reset_again();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule